// File: doc/BRIEF.md
# Board Control Register File

A memory-mapped block of control and status registers for a development board. A host reaches it through a simple bus with single-cycle access. Each access carries a 20-bit offset, a write strobe and 32-bit write data. The block holds an eight-LED bar, an eight-character ASCII display buffer, a break byte, a general-purpose output byte and a bit-banged I2C control set. The I2C set drives SCL and SDA strobes toward an EEPROM responder and reads back that responder's SDA line. The block also returns fixed revision and status words, and it raises a one-cycle system-reset request when the host writes a magic value.

The display buffer can be loaded in two ways. One write can load all eight characters as the uppercase hex rendering of a 32-bit word. A single write can also replace one character. The offset window 0x900–0x9FF belongs to a neighbouring serial port. This block ignores that window completely. Any other access to an offset that has no register, or that uses a direction the register does not support, raises a one-cycle bad-address flag.

Read data is registered. The reset request comes from a two-state generator: `RG_IDLE` moves to `RG_FIRE` on a magic write. `RG_FIRE` moves back to `RG_IDLE`, or stays in `RG_FIRE` when another magic write arrives in the same cycle. The request output is high only while the generator is in `RG_FIRE`.

Top module: `board_ctl_regs`

## Requirements
- R1: After reset: led_o=0x00, brk_o=0x0A, gpo_o=0x00, i2c_oe_o=0, the I2C output word=0x3 (i2c_scl_o=1, i2c_sda_o=1), the I2C select bit=1, every display character=0x20, and sys_rst_req_o=0 and bad_addr_o=0.
- R2: Offsets 0x408 (LED), 0x508 (break) and 0xA00 (general output) each store write-data bits 7..0. Each drives its output port and reads back zero-extended.
- R3: A write to 0x410 sets display character k (disp_o bits 8k+7..8k) to the uppercase ASCII hex digit of write-data nibble 7−k. Digits 0–9 map to 0x30–0x39 and A–F map to 0x41–0x46.
- R4: A write to offset 0x418+8k (k = 0..7) sets display character k to write-data bits 7..0. The other characters are left unchanged.
- R5: A write of exactly 0x00000042 to 0x500 drives sys_rst_req_o high for exactly the one cycle after the write. Any other value written there has no effect.
- R6: A write to 0xB10 stores the full 32-bit word. i2c_scl_o follows bit 1 and i2c_sda_o follows bit 0, and a read of 0xB10 returns the word. 0xB08 stores bits 1..0 as i2c_oe_o. 0xB18 stores bit 0 as the select bit. Both read back.
- R7: A read of 0xB00 returns 0x2 OR'd with the value of i2c_sda_i in the access cycle.
- R8: A read of 0xA08 returns the I2C output word when the select bit is 1, and 0 otherwise.
- R9: Reads of 0x200 and 0x210 return 0. A read of 0x208 returns 0x12 when BIG_END=1 and 0x10 otherwise.
- R10: bus_rdata updates in the cycle after a read access and holds its value through idle cycles and writes.
- R11: An access to an offset outside 0x900–0x9FF raises bad_addr_o for one cycle when no register exists there in that direction. The write-only offsets are 0x410–0x450 and 0x500. The read-only offsets are 0x208, 0xA08 and 0xB00. Such reads return 0 and such writes change nothing.
- R12: Accesses in 0x900–0x9FF never raise bad_addr_o, read as 0 and change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_ofs | input | 20 | Register offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| led_o | output | 8 | LED bar |
| brk_o | output | 8 | Break byte |
| gpo_o | output | 8 | General-purpose outputs |
| disp_o | output | 64 | Display characters, character k in bits 8k+7..8k |
| i2c_oe_o | output | 2 | I2C output enables |
| i2c_scl_o | output | 1 | SCL strobe to the EEPROM responder |
| i2c_sda_o | output | 1 | SDA strobe to the EEPROM responder |
| i2c_sda_i | input | 1 | SDA returned by the responder |
| sys_rst_req_o | output | 1 | One-cycle system reset request |
| bad_addr_o | output | 1 | One-cycle flag for an unmapped access |

## Verification
The properties assume that bus_sel, bus_wr, bus_ofs and bus_wdata are stable around each rising clock edge. They also assume that at most one access arrives per cycle and that rst_n is held low for at least one edge before use. The bench changes every input only on falling edges and holds an access for exactly one cycle. It keeps reset low for several cycles at the start. It sweeps every word offset from 0x000 to 0xBFC in both directions, and it writes only to offsets that the requirements class as unmapped or foreign, so that the registers it has already loaded keep known values.

// File: rtl/bcr_pkg.sv
package bcr_pkg;

    localparam int OFS_W  = 20;
    localparam int DATA_W = 32;
    localparam int BYTE_W = 8;

    localparam logic [OFS_W-1:0] OFS_ZERO_A  = 20'h00200;
    localparam logic [OFS_W-1:0] OFS_REV     = 20'h00208;
    localparam logic [OFS_W-1:0] OFS_ZERO_B  = 20'h00210;
    localparam logic [OFS_W-1:0] OFS_LED     = 20'h00408;
    localparam logic [OFS_W-1:0] OFS_HEX     = 20'h00410;
    localparam logic [OFS_W-1:0] OFS_CHAR0   = 20'h00418;
    localparam logic [OFS_W-1:0] OFS_RST     = 20'h00500;
    localparam logic [OFS_W-1:0] OFS_BRK     = 20'h00508;
    localparam logic [OFS_W-1:0] OFS_FOREIGN_LO = 20'h00900;
    localparam logic [OFS_W-1:0] OFS_FOREIGN_HI = 20'h009FF;
    localparam logic [OFS_W-1:0] OFS_GPO     = 20'h00A00;
    localparam logic [OFS_W-1:0] OFS_MIRROR  = 20'h00A08;
    localparam logic [OFS_W-1:0] OFS_I2C_IN  = 20'h00B00;
    localparam logic [OFS_W-1:0] OFS_I2C_OE  = 20'h00B08;
    localparam logic [OFS_W-1:0] OFS_I2C_OUT = 20'h00B10;
    localparam logic [OFS_W-1:0] OFS_I2C_SEL = 20'h00B18;

    localparam logic [DATA_W-1:0] RST_MAGIC = 32'h0000_0042;

    typedef enum logic [3:0] {
        RS_NONE,
        RS_FOREIGN,
        RS_ZERO,
        RS_REV,
        RS_LED,
        RS_HEX,
        RS_CHAR,
        RS_RST,
        RS_BRK,
        RS_GPO,
        RS_MIRROR,
        RS_I2C_IN,
        RS_I2C_OE,
        RS_I2C_OUT,
        RS_I2C_SEL
    } reg_sel_e;

    function automatic logic [BYTE_W-1:0] nib_to_ascii(input logic [3:0] n);
        if (n < 4'd10) nib_to_ascii = 8'h30 + {4'd0, n};
        else           nib_to_ascii = 8'h37 + {4'd0, n};
    endfunction

endpackage

// File: rtl/bcr_decode.sv
module bcr_decode
    import bcr_pkg::*;
#(
    parameter int NCHAR = 8,
    localparam int IDX_W = $clog2(NCHAR)
) (
    input  logic [OFS_W-1:0] ofs,
    output reg_sel_e         sel,
    output logic             rd_ok,
    output logic             wr_ok,
    output logic [IDX_W-1:0] char_idx
);
    localparam logic [OFS_W-1:0] CHAR_LAST = OFS_CHAR0 + OFS_W'((NCHAR - 1) * 8);

    logic in_char;

    assign in_char  = (ofs >= OFS_CHAR0) && (ofs <= CHAR_LAST) && (ofs[2:0] == 3'd0);
    assign char_idx = ofs[3 +: IDX_W] - OFS_CHAR0[3 +: IDX_W];

    always_comb begin
        sel = RS_NONE;
        if ((ofs >= OFS_FOREIGN_LO) && (ofs <= OFS_FOREIGN_HI)) begin
            sel = RS_FOREIGN;
        end else if (in_char) begin
            sel = RS_CHAR;
        end else begin
            case (ofs)
                OFS_ZERO_A, OFS_ZERO_B: sel = RS_ZERO;
                OFS_REV:     sel = RS_REV;
                OFS_LED:     sel = RS_LED;
                OFS_HEX:     sel = RS_HEX;
                OFS_RST:     sel = RS_RST;
                OFS_BRK:     sel = RS_BRK;
                OFS_GPO:     sel = RS_GPO;
                OFS_MIRROR:  sel = RS_MIRROR;
                OFS_I2C_IN:  sel = RS_I2C_IN;
                OFS_I2C_OE:  sel = RS_I2C_OE;
                OFS_I2C_OUT: sel = RS_I2C_OUT;
                OFS_I2C_SEL: sel = RS_I2C_SEL;
                default:     sel = RS_NONE;
            endcase
        end
    end

    always_comb begin
        rd_ok = 1'b0;
        wr_ok = 1'b0;
        unique case (sel)
            RS_ZERO, RS_LED, RS_BRK, RS_GPO, RS_I2C_OE, RS_I2C_OUT, RS_I2C_SEL: begin
                rd_ok = 1'b1;
                wr_ok = 1'b1;
            end
            RS_REV, RS_MIRROR, RS_I2C_IN: rd_ok = 1'b1;
            RS_HEX, RS_CHAR, RS_RST:      wr_ok = 1'b1;
            default: begin
                rd_ok = 1'b0;
                wr_ok = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/bcr_display.sv
module bcr_display
    import bcr_pkg::*;
#(
    parameter int NCHAR = 8,
    localparam int IDX_W = $clog2(NCHAR)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    hex_we,
    input  logic                    chr_we,
    input  logic [IDX_W-1:0]        chr_idx,
    input  logic [DATA_W-1:0]       wdata,
    output logic [NCHAR*BYTE_W-1:0] disp
);
    localparam logic [BYTE_W-1:0] BLANK = 8'h20;

    for (genvar k = 0; k < NCHAR; k++) begin : g_char
        logic [BYTE_W-1:0] ch_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ch_q <= BLANK;
            end else if (hex_we) begin
                ch_q <= nib_to_ascii(wdata[4*(NCHAR-1-k) +: 4]);
            end else if (chr_we && (chr_idx == IDX_W'(k))) begin
                ch_q <= wdata[BYTE_W-1:0];
            end
        end
        assign disp[k*BYTE_W +: BYTE_W] = ch_q;
    end
endmodule

// File: rtl/bcr_rstgen.sv
module bcr_rstgen (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic pulse
);
    typedef enum logic {RG_IDLE, RG_FIRE} rg_state_e;

    rg_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RG_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        pulse   = 1'b0;
        unique case (state_q)
            RG_IDLE: if (fire) state_d = RG_FIRE;
            RG_FIRE: begin
                pulse   = 1'b1;
                state_d = fire ? RG_FIRE : RG_IDLE;
            end
            default: state_d = RG_IDLE;
        endcase
    end
endmodule

// File: rtl/board_ctl_regs.sv
module board_ctl_regs
    import bcr_pkg::*;
#(
    parameter bit BIG_END = 1'b0,
    parameter int NCHAR   = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_sel,
    input  logic                    bus_wr,
    input  logic [OFS_W-1:0]        bus_ofs,
    input  logic [DATA_W-1:0]       bus_wdata,
    output logic [DATA_W-1:0]       bus_rdata,
    output logic [BYTE_W-1:0]       led_o,
    output logic [BYTE_W-1:0]       brk_o,
    output logic [BYTE_W-1:0]       gpo_o,
    output logic [NCHAR*BYTE_W-1:0] disp_o,
    output logic [1:0]              i2c_oe_o,
    output logic                    i2c_scl_o,
    output logic                    i2c_sda_o,
    input  logic                    i2c_sda_i,
    output logic                    sys_rst_req_o,
    output logic                    bad_addr_o
);
    localparam int IDX_W = $clog2(NCHAR);
    localparam logic [DATA_W-1:0] REV_WORD   = BIG_END ? 32'h12 : 32'h10;
    localparam logic [DATA_W-1:0] I2C_IN_RST = 32'h3;
    localparam logic [DATA_W-1:0] I2C_OUT_RST = 32'h3;
    localparam logic [BYTE_W-1:0] BRK_RST    = 8'h0A;

    reg_sel_e         sel;
    logic             rd_ok, wr_ok;
    logic [IDX_W-1:0] char_idx;
    logic             wr_hit, rd_acc;
    logic [DATA_W-1:0] rd_mux;

    logic [BYTE_W-1:0] led_q, brk_q, gpo_q;
    logic [1:0]        oe_q;
    logic [DATA_W-1:0] out_q;
    logic              isel_q;
    logic [DATA_W-1:0] rd_q;
    logic              bad_q;

    bcr_decode #(.NCHAR(NCHAR)) u_dec (
        .ofs      (bus_ofs),
        .sel      (sel),
        .rd_ok    (rd_ok),
        .wr_ok    (wr_ok),
        .char_idx (char_idx)
    );

    assign wr_hit = bus_sel && bus_wr && wr_ok;
    assign rd_acc = bus_sel && !bus_wr;

    bcr_display #(.NCHAR(NCHAR)) u_disp (
        .clk     (clk),
        .rst_n   (rst_n),
        .hex_we  (wr_hit && (sel == RS_HEX)),
        .chr_we  (wr_hit && (sel == RS_CHAR)),
        .chr_idx (char_idx),
        .wdata   (bus_wdata),
        .disp    (disp_o)
    );

    bcr_rstgen u_rst (
        .clk   (clk),
        .rst_n (rst_n),
        .fire  (wr_hit && (sel == RS_RST) && (bus_wdata == RST_MAGIC)),
        .pulse (sys_rst_req_o)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            led_q  <= '0;
            brk_q  <= BRK_RST;
            gpo_q  <= '0;
            oe_q   <= '0;
            out_q  <= I2C_OUT_RST;
            isel_q <= 1'b1;
        end else if (wr_hit) begin
            case (sel)
                RS_LED:     led_q  <= bus_wdata[BYTE_W-1:0];
                RS_BRK:     brk_q  <= bus_wdata[BYTE_W-1:0];
                RS_GPO:     gpo_q  <= bus_wdata[BYTE_W-1:0];
                RS_I2C_OE:  oe_q   <= bus_wdata[1:0];
                RS_I2C_OUT: out_q  <= bus_wdata;
                RS_I2C_SEL: isel_q <= bus_wdata[0];
                default: ;
            endcase
        end
    end

    always_comb begin
        rd_mux = '0;
        case (sel)
            RS_REV:     rd_mux = REV_WORD;
            RS_LED:     rd_mux = {{(DATA_W-BYTE_W){1'b0}}, led_q};
            RS_BRK:     rd_mux = {{(DATA_W-BYTE_W){1'b0}}, brk_q};
            RS_GPO:     rd_mux = {{(DATA_W-BYTE_W){1'b0}}, gpo_q};
            RS_MIRROR:  rd_mux = isel_q ? out_q : '0;
            RS_I2C_IN:  rd_mux = {I2C_IN_RST[DATA_W-1:1], i2c_sda_i};
            RS_I2C_OE:  rd_mux = {{(DATA_W-2){1'b0}}, oe_q};
            RS_I2C_OUT: rd_mux = out_q;
            RS_I2C_SEL: rd_mux = {{(DATA_W-1){1'b0}}, isel_q};
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q  <= '0;
            bad_q <= 1'b0;
        end else begin
            if (rd_acc) rd_q <= rd_ok ? rd_mux : '0;
            bad_q <= bus_sel && (sel != RS_FOREIGN) && (bus_wr ? !wr_ok : !rd_ok);
        end
    end

    assign bus_rdata  = rd_q;
    assign bad_addr_o = bad_q;
    assign led_o      = led_q;
    assign brk_o      = brk_q;
    assign gpo_o      = gpo_q;
    assign i2c_oe_o   = oe_q;
    assign i2c_scl_o  = out_q[1];
    assign i2c_sda_o  = out_q[0];
endmodule

// File: rtl/board_ctl_regs_chk.sv
module board_ctl_regs_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_sel,
    input logic        bus_wr,
    input logic [19:0] bus_ofs,
    input logic [31:0] bus_wdata,
    input logic [7:0]  led_o,
    input logic        i2c_scl_o,
    input logic        i2c_sda_o,
    input logic        sys_rst_req_o,
    input logic        bad_addr_o
);
    logic magic_wr, led_wr, pin_wr, foreign;

    assign magic_wr = bus_sel && bus_wr && (bus_ofs == 20'h00500) && (bus_wdata == 32'h42);
    assign led_wr   = bus_sel && bus_wr && (bus_ofs == 20'h00408);
    assign pin_wr   = bus_sel && bus_wr && (bus_ofs == 20'h00B10);
    assign foreign  = bus_sel && (bus_ofs >= 20'h00900) && (bus_ofs <= 20'h009FF);

    a_r5_pulse_after_magic: assert property (@(posedge clk) disable iff (!rst_n)
        magic_wr |=> sys_rst_req_o);

    a_r5_no_pulse_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
        !magic_wr |=> !sys_rst_req_o);

    a_r2_led_load: assert property (@(posedge clk) disable iff (!rst_n)
        led_wr |=> (led_o == $past(bus_wdata[7:0])));

    a_r6_pins_follow: assert property (@(posedge clk) disable iff (!rst_n)
        pin_wr |=> ({i2c_scl_o, i2c_sda_o} == $past(bus_wdata[1:0])));

    a_r6_pins_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_wr |=> $stable({i2c_scl_o, i2c_sda_o}));

    a_r12_foreign_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        foreign |=> !bad_addr_o);

    a_r11_flag_needs_access: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_sel |=> !bad_addr_o);
endmodule

bind board_ctl_regs board_ctl_regs_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_sel       (bus_sel),
    .bus_wr        (bus_wr),
    .bus_ofs       (bus_ofs),
    .bus_wdata     (bus_wdata),
    .led_o         (led_o),
    .i2c_scl_o     (i2c_scl_o),
    .i2c_sda_o     (i2c_sda_o),
    .sys_rst_req_o (sys_rst_req_o),
    .bad_addr_o    (bad_addr_o)
);

// File: tb/tb_board_ctl_regs.sv
module tb_board_ctl_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [19:0] bus_ofs = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  led_o, brk_o, gpo_o;
    logic [63:0] disp_o;
    logic [1:0]  i2c_oe_o;
    logic        i2c_scl_o, i2c_sda_o;
    logic        i2c_sda_i = 1'b1;
    logic        sys_rst_req_o, bad_addr_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    board_ctl_regs dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_ofs(bus_ofs), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .led_o(led_o), .brk_o(brk_o), .gpo_o(gpo_o), .disp_o(disp_o),
        .i2c_oe_o(i2c_oe_o), .i2c_scl_o(i2c_scl_o), .i2c_sda_o(i2c_sda_o),
        .i2c_sda_i(i2c_sda_i), .sys_rst_req_o(sys_rst_req_o), .bad_addr_o(bad_addr_o)
    );

    always #2 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic acc(input bit wr, input logic [19:0] ofs, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = wr; bus_ofs = ofs; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [19:0] ofs, input logic [31:0] exp, input string tag);
        acc(1'b0, ofs, 32'h0);
        chk(bus_rdata == exp, tag, bus_rdata, exp);
    endtask

    function automatic logic [7:0] hexc(input logic [3:0] n);
        return (n < 10) ? (8'd48 + n) : (8'd55 + n);
    endfunction

    function automatic bit rd_mapped(input int o);
        return o == 'h200 || o == 'h208 || o == 'h210 || o == 'h408 || o == 'h508 ||
               o == 'hA00 || o == 'hA08 || o == 'hB00 || o == 'hB08 || o == 'hB10 || o == 'hB18;
    endfunction

    function automatic bit wr_mapped(input int o);
        return o == 'h200 || o == 'h210 || o == 'h408 || o == 'h410 || o == 'h500 ||
               o == 'h508 || o == 'hA00 || o == 'hB08 || o == 'hB10 || o == 'hB18 ||
               (o >= 'h418 && o <= 'h450 && (o % 8) == 0);
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] pats [3];
        logic [63:0] snap_disp;
        logic [7:0]  snap_led, snap_brk, snap_gpo;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values
        chk(led_o == 8'h00, "R1 led", led_o, 0);
        chk(brk_o == 8'h0A, "R1 brk", brk_o, 8'h0A);
        chk(gpo_o == 8'h00, "R1 gpo", gpo_o, 0);
        chk(i2c_oe_o == 2'd0, "R1 oe", i2c_oe_o, 0);
        chk({i2c_scl_o, i2c_sda_o} == 2'b11, "R1 pins", {i2c_scl_o, i2c_sda_o}, 3);
        chk(disp_o == {8{8'h20}}, "R1 display", disp_o, {8{8'h20}});
        chk(!sys_rst_req_o && !bad_addr_o, "R1 pulses", {sys_rst_req_o, bad_addr_o}, 0);
        rd_chk('hB10, 32'h3, "R1 i2c out word");
        rd_chk('hB18, 32'h1, "R1 select");

        // R2 byte registers
        acc(1'b1, 'h408, 32'hDEADBE5A);
        chk(led_o == 8'h5A, "R2 led", led_o, 8'h5A);
        rd_chk('h408, 32'h5A, "R2 led read");
        acc(1'b1, 'h508, 32'h1234_56C3);
        chk(brk_o == 8'hC3, "R2 brk", brk_o, 8'hC3);
        rd_chk('h508, 32'hC3, "R2 brk read");
        acc(1'b1, 'hA00, 32'hFFFF_FF81);
        chk(gpo_o == 8'h81, "R2 gpo", gpo_o, 8'h81);
        rd_chk('hA00, 32'h81, "R2 gpo read");

        // R3 hex load
        pats[0] = 32'h0123_4567; pats[1] = 32'h89AB_CDEF; pats[2] = 32'hFEDC_BA98;
        for (int p = 0; p < 3; p++) begin
            acc(1'b1, 'h410, pats[p]);
            for (int k = 0; k < 8; k++) begin
                logic [7:0] e;
                e = hexc(pats[p][4*(7-k) +: 4]);
                chk(disp_o[8*k +: 8] == e, "R3 hex char", disp_o[8*k +: 8], e);
            end
        end

        // R4 per-character writes
        for (int k = 0; k < 8; k++) begin
            acc(1'b1, 20'(32'h418 + 8 * k), 32'hFFFF_FF00 | (32'h61 + k));
            for (int j = 0; j < 8; j++) begin
                logic [7:0] e;
                e = (j <= k) ? 8'(8'h61 + j) : hexc(pats[2][4*(7-j) +: 4]);
                chk(disp_o[8*j +: 8] == e, "R4 char", disp_o[8*j +: 8], e);
            end
        end

        // R5 reset trigger
        acc(1'b1, 'h500, 32'h43);
        chk(!sys_rst_req_o, "R5 wrong value", sys_rst_req_o, 0);
        acc(1'b1, 'h500, 32'h142);
        chk(!sys_rst_req_o, "R5 wide value", sys_rst_req_o, 0);
        acc(1'b1, 'h500, 32'h42);
        chk(sys_rst_req_o, "R5 pulse", sys_rst_req_o, 1);
        @(negedge clk);
        chk(!sys_rst_req_o, "R5 pulse end", sys_rst_req_o, 0);

        // R6 I2C set
        acc(1'b1, 'hB10, 32'h2);
        chk({i2c_scl_o, i2c_sda_o} == 2'b10, "R6 pins 10", {i2c_scl_o, i2c_sda_o}, 2);
        acc(1'b1, 'hB10, 32'hABCD_0001);
        chk({i2c_scl_o, i2c_sda_o} == 2'b01, "R6 pins 01", {i2c_scl_o, i2c_sda_o}, 1);
        rd_chk('hB10, 32'hABCD_0001, "R6 out read");
        acc(1'b1, 'hB08, 32'hFF);
        chk(i2c_oe_o == 2'd3, "R6 oe", i2c_oe_o, 3);
        rd_chk('hB08, 32'h3, "R6 oe read");

        // R8 mirror depends on select
        rd_chk('hA08, 32'hABCD_0001, "R8 mirror sel1");
        acc(1'b1, 'hB18, 32'h2);
        rd_chk('hB18, 32'h0, "R6 select read");
        rd_chk('hA08, 32'h0, "R8 mirror sel0");
        acc(1'b1, 'hB18, 32'h1);

        // R7 live SDA
        i2c_sda_i = 1'b0;
        rd_chk('hB00, 32'h2, "R7 sda0");
        i2c_sda_i = 1'b1;
        rd_chk('hB00, 32'h3, "R7 sda1");

        // R9 fixed words
        rd_chk('h200, 32'h0, "R9 zero a");
        rd_chk('h208, 32'h10, "R9 revision");
        rd_chk('h210, 32'h0, "R9 zero b");

        // R10 read data hold
        rd_chk('h408, 32'h5A, "R10 read");
        @(negedge clk);
        chk(bus_rdata == 32'h5A, "R10 hold idle", bus_rdata, 32'h5A);
        acc(1'b1, 'hA00, 32'h81);
        chk(bus_rdata == 32'h5A, "R10 hold write", bus_rdata, 32'h5A);

        // R11 / R12 read sweep
        for (int o = 0; o < 'hC00; o += 4) begin
            bit foreign, expbad;
            foreign = (o >= 'h900 && o <= 'h9FF);
            expbad  = !foreign && !rd_mapped(o);
            acc(1'b0, 20'(o), 32'h0);
            chk(bad_addr_o == expbad, foreign ? "R12 read flag" : "R11 read flag", bad_addr_o, expbad);
            if (foreign || expbad)
                chk(bus_rdata == 0, foreign ? "R12 read zero" : "R11 read zero", bus_rdata, 0);
            @(negedge clk);
            chk(!bad_addr_o, "R11 flag one cycle", bad_addr_o, 0);
        end

        // R11 / R12 write sweep
        snap_disp = disp_o; snap_led = led_o; snap_brk = brk_o; snap_gpo = gpo_o;
        for (int o = 0; o < 'hC00; o += 4) begin
            bit foreign;
            foreign = (o >= 'h900 && o <= 'h9FF);
            if (!wr_mapped(o)) begin
                acc(1'b1, 20'(o), 32'hFFFF_FFFF);
                chk(bad_addr_o == !foreign, foreign ? "R12 write flag" : "R11 write flag", bad_addr_o, !foreign);
                chk(!sys_rst_req_o, "R11 write no pulse", sys_rst_req_o, 0);
            end
        end
        chk(disp_o == snap_disp, "R11 display kept", disp_o, snap_disp);
        chk({led_o, brk_o, gpo_o} == {snap_led, snap_brk, snap_gpo}, "R12 bytes kept",
            {led_o, brk_o, gpo_o}, {snap_led, snap_brk, snap_gpo});
        chk({i2c_oe_o, i2c_scl_o, i2c_sda_o} == 4'b1101, "R12 i2c kept",
            {i2c_oe_o, i2c_scl_o, i2c_sda_o}, 4'b1101);
        rd_chk('hB18, 32'h1, "R11 select kept");

        finish_run();
    end
endmodule